// File: doc/BRIEF.md
# Perturb-and-Observe Solar Duty Controller

This block sets the duty cycle of a fixed-frequency boost converter that draws power from a solar source. It also produces the switching waveform itself. Once per tracking period it multiplies a digitized input-voltage sample by an input-current sample. It compares that power with the value from the previous period and moves the duty cycle by a fixed step. The direction of the step is remembered and is reversed only when power has fallen. The tracked duty stays inside a floor and a ceiling of 90 % of the switching period.

Digital flags from the analog front end supervise tracking. Overcurrent and overtemperature flags silence the switch output. Output-voltage and output-current regulation flags take control of the duty and walk it downward. Two input-level flags sequence the startup and the burst pauses: one shows the 0.3 V startup level, the other the 0.45 V running level.

The controller is one state machine with four states: `ST_IDLE` (code 0), `ST_TRACK` (code 1), `ST_REGULATE` (code 2) and `ST_BURST` (code 3). Its transitions are:
- power-up: `ST_IDLE` → `ST_TRACK`
- regulation entry: `ST_TRACK` → `ST_REGULATE`
- regulation release: `ST_REGULATE` → `ST_TRACK`
- sag: `ST_TRACK` or `ST_REGULATE` → `ST_BURST`
- recovery: `ST_BURST` → `ST_TRACK`
- collapse: `ST_BURST` → `ST_IDLE`

Top module: `mppt_duty_ctrl`

## Requirements
- R1: After reset, and for as long as `start_ok_i` stays low, `mode_o` is 0 (idle), `duty_o` equals DUTY_MIN, `dir_up_o` is 1 and `pwm_o` is low.
- R2: In idle, a high `start_ok_i` moves `mode_o` to 1 (tracking) on the next clock edge, and switching begins on the edge after that.
- R3: The first tracking tick after any entry into tracking only stores the power; `duty_o` and `dir_up_o` do not change at that tick.
- R4: At every later tracking tick the power is formed as the unsigned product `v_sample_i * i_sample_i`. If it is not below the stored power, the duty steps in the remembered direction. If it is below, `dir_up_o` is inverted first and the duty then steps in the new direction. The new power is then stored.
- R5: Each duty change made by tracking or regulation is exactly STEP counts. The result is clamped to the range DUTY_MIN to DUTY_MAX, where DUTY_MAX = floor(9 × PWM_PERIOD / 10).
- R6: The PWM period is PWM_PERIOD = CLK_HZ / PWM_HZ clock cycles. While switching is enabled, `pwm_o` is high for exactly `duty_o` cycles of each period. The output is registered, one cycle behind its controls.
- R7: While `ovc_i` or `ovt_i` is high, `pwm_o` is low from the next cycle on, and tracking ticks change neither `duty_o` nor `dir_up_o`.
- R8: In tracking, a high `vreg_i` or `ireg_i` moves `mode_o` to 2 (regulation). There each tick lowers `duty_o` by STEP, clamped at DUTY_MIN, while `dir_up_o` is kept.
- R9: When both regulation flags are low in regulation, the block returns to tracking with the stored power forgotten, so R3 applies again.
- R10: A low `run_ok_i` in tracking or regulation moves `mode_o` to 3 (burst). This takes precedence over regulation. In burst, `pwm_o` is low and `duty_o` is held.
- R11: In burst, a low `start_ok_i` returns the block to idle with `duty_o` at DUTY_MIN and `dir_up_o` at 1. Otherwise a high `run_ok_i` returns it to tracking with the stored power forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_sample_i | input | SAMPLE_W | Input-voltage sample |
| i_sample_i | input | SAMPLE_W | Input-current sample |
| start_ok_i | input | 1 | Input above startup level |
| run_ok_i | input | 1 | Input above running level |
| ovc_i | input | 1 | Switch overcurrent flag |
| ovt_i | input | 1 | Overtemperature flag |
| vreg_i | input | 1 | Output-voltage regulation request |
| ireg_i | input | 1 | Output-current regulation request |
| pwm_o | output | 1 | Switch drive |
| duty_o | output | DUTY_W | Present duty in clock cycles |
| dir_up_o | output | 1 | Remembered step direction, 1 = increase |
| mode_o | output | 2 | State code (0 idle, 1 tracking, 2 regulation, 3 burst) |

## Verification
A tracking tick and a protection stop can fall in the same cycle. The duty update and the switch gating then both act on the same edge. The bench provokes this by holding `ovc_i` or `ovt_i` high across whole tracking periods, both in directed steps with a falling power and in the random phase. It judges the outcome by checking that duty and direction equal their values from before the tick, and by counting zero high cycles of `pwm_o` in a full PWM period. Regulation requests that coincide with a sag are judged in the same way: the block must end in burst, not in regulation.

// File: rtl/mppt_pkg.sv
package mppt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_TRACK    = 2'd1,
        ST_REGULATE = 2'd2,
        ST_BURST    = 2'd3
    } trk_state_e;

endpackage

// File: rtl/mppt_tick_timer.sv
// Free-running strobe once every PERIOD cycles (PERIOD >= 2).
module mppt_tick_timer #(
    parameter int PERIOD = 10_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mppt_power_mult.sv
// Unsigned power estimate from one voltage and one current sample.
module mppt_power_mult #(
    parameter int SAMPLE_W = 12,
    parameter int POW_W    = 2 * SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] v_i,
    input  logic [SAMPLE_W-1:0] i_i,
    output logic [POW_W-1:0]    p_o
);
    assign p_o = POW_W'(v_i) * POW_W'(i_i);
endmodule

// File: rtl/mppt_pwm_gen.sv
// Fixed-period edge-aligned modulator with a registered output.
module mppt_pwm_gen #(
    parameter int PERIOD = 100,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [DW-1:0] duty_i,
    output logic          pwm_o
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pwm_o <= 1'b0;
        else
            pwm_o <= en_i && (DW'(phase_q) < duty_i);
    end
endmodule

// File: rtl/mppt_duty_ctrl.sv
module mppt_duty_ctrl
    import mppt_pkg::*;
#(
    parameter int CLK_HZ       = 10_000_000,
    parameter int PWM_HZ       = 100_000,
    parameter int TRACK_CYCLES = 10_000,
    parameter int SAMPLE_W     = 12,
    parameter int DUTY_MIN     = 5,
    parameter int STEP         = 1,
    parameter int DUTY_W       = $clog2(CLK_HZ / PWM_HZ + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] v_sample_i,
    input  logic [SAMPLE_W-1:0] i_sample_i,
    input  logic                start_ok_i,
    input  logic                run_ok_i,
    input  logic                ovc_i,
    input  logic                ovt_i,
    input  logic                vreg_i,
    input  logic                ireg_i,
    output logic                pwm_o,
    output logic [DUTY_W-1:0]   duty_o,
    output logic                dir_up_o,
    output logic [1:0]          mode_o
);
    localparam int PWM_PERIOD = CLK_HZ / PWM_HZ;
    localparam int DUTY_MAX   = (PWM_PERIOD * 9) / 10;
    localparam int POW_W      = 2 * SAMPLE_W;

    localparam logic [DUTY_W:0]   MAX_X   = (DUTY_W + 1)'(DUTY_MAX);
    localparam logic [DUTY_W:0]   MIN_X   = (DUTY_W + 1)'(DUTY_MIN);
    localparam logic [DUTY_W:0]   STEP_X  = (DUTY_W + 1)'(STEP);
    localparam logic [DUTY_W-1:0] MAX_D   = DUTY_W'(DUTY_MAX);
    localparam logic [DUTY_W-1:0] MIN_D   = DUTY_W'(DUTY_MIN);

    trk_state_e        state_q, state_d;
    logic              tick;
    logic [POW_W-1:0]  power;
    logic [POW_W-1:0]  prev_q;
    logic              prev_ok_q;
    logic [DUTY_W-1:0] duty_q;
    logic              dir_q;
    logic              pwm_en;
    logic              halt;
    logic              reg_req;

    // ---------------- helpers ----------------
    mppt_tick_timer #(
        .PERIOD (TRACK_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    mppt_power_mult #(
        .SAMPLE_W (SAMPLE_W),
        .POW_W    (POW_W)
    ) u_mult (
        .v_i (v_sample_i),
        .i_i (i_sample_i),
        .p_o (power)
    );

    mppt_pwm_gen #(
        .PERIOD (PWM_PERIOD),
        .DW     (DUTY_W)
    ) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pwm_en),
        .duty_i (duty_q),
        .pwm_o  (pwm_o)
    );

    assign halt    = ovc_i | ovt_i;
    assign reg_req = vreg_i | ireg_i;

    // ---------------- step arithmetic ----------------
    logic [DUTY_W:0]   duty_x;
    logic [DUTY_W:0]   up_sum;
    logic [DUTY_W-1:0] duty_up;
    logic [DUTY_W-1:0] duty_dn;
    logic              power_fell;
    logic              dir_next;
    logic [DUTY_W-1:0] duty_track;

    assign duty_x     = {1'b0, duty_q};
    assign up_sum     = duty_x + STEP_X;
    assign duty_up    = (up_sum > MAX_X) ? MAX_D : up_sum[DUTY_W-1:0];
    assign duty_dn    = (duty_x < (MIN_X + STEP_X)) ? MIN_D
                                                    : DUTY_W'(duty_x - STEP_X);
    assign power_fell = (power < prev_q);
    assign dir_next   = dir_q ^ power_fell;
    assign duty_track = dir_next ? duty_up : duty_dn;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok_i)        state_d = ST_TRACK;     // power-up
            end
            ST_TRACK: begin
                if (!run_ok_i)         state_d = ST_BURST;     // sag
                else if (reg_req)      state_d = ST_REGULATE;  // regulation entry
            end
            ST_REGULATE: begin
                if (!run_ok_i)         state_d = ST_BURST;     // sag
                else if (!reg_req)     state_d = ST_TRACK;     // regulation release
            end
            ST_BURST: begin
                if (!start_ok_i)       state_d = ST_IDLE;      // collapse
                else if (run_ok_i)     state_d = ST_TRACK;     // recovery
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- tracking registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q    <= MIN_D;
            dir_q     <= 1'b1;
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else if (state_d != state_q) begin
            unique case (state_d)
                ST_IDLE: begin
                    duty_q    <= MIN_D;
                    dir_q     <= 1'b1;
                    prev_ok_q <= 1'b0;
                end
                ST_TRACK: prev_ok_q <= 1'b0;
                default: ;
            endcase
        end else if (tick && !halt) begin
            unique case (state_q)
                ST_TRACK: begin
                    prev_q    <= power;
                    prev_ok_q <= 1'b1;
                    if (prev_ok_q) begin
                        dir_q  <= dir_next;
                        duty_q <= duty_track;
                    end
                end
                ST_REGULATE: duty_q <= duty_dn;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        pwm_en = 1'b0;
        unique case (state_q)
            ST_TRACK, ST_REGULATE: pwm_en = !halt;
            default:               pwm_en = 1'b0;
        endcase
    end

    assign duty_o   = duty_q;
    assign dir_up_o = dir_q;
    assign mode_o   = state_q;
endmodule

// File: rtl/mppt_duty_ctrl_chk.sv
module mppt_duty_ctrl_chk #(
    parameter int DW       = 7,
    parameter int DUTY_MIN = 5,
    parameter int DUTY_MAX = 90,
    parameter int STEP     = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ovc_i,
    input logic          ovt_i,
    input logic          pwm_o,
    input logic [DW-1:0] duty_o,
    input logic [1:0]    mode_o
);
    // R5: duty never above the 90 % ceiling
    p_duty_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(duty_o) <= DUTY_MAX);

    // R5: duty never below the floor
    p_duty_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(duty_o) >= DUTY_MIN);

    // R5: outside a return to idle, duty moves by at most one step per cycle
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0) |=> (mode_o == 2'd0) ||
            ((int'(duty_o) - int'($past(duty_o)) <= STEP) &&
             (int'($past(duty_o)) - int'(duty_o) <= STEP)));

    // R7: a protection flag silences the switch on the next cycle
    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovc_i || ovt_i) |=> !pwm_o);

    // R1: no switching from idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0) |=> !pwm_o);

    // R10: no switching from burst
    p_burst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> !pwm_o);

    // R8: regulation never raises the duty
    p_reg_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |=> int'(duty_o) <= int'($past(duty_o)));
endmodule

bind mppt_duty_ctrl mppt_duty_ctrl_chk #(
    .DW       (DUTY_W),
    .DUTY_MIN (DUTY_MIN),
    .DUTY_MAX (DUTY_MAX),
    .STEP     (STEP)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ovc_i  (ovc_i),
    .ovt_i  (ovt_i),
    .pwm_o  (pwm_o),
    .duty_o (duty_o),
    .mode_o (mode_o)
);

// File: tb/sim_mppt_duty_ctrl.sv
module sim_mppt_duty_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 2_000_000;
    localparam int PWM_HZ     = 100_000;
    localparam int TRK        = 64;
    localparam int SW         = 12;
    localparam int DMIN       = 2;
    localparam int STEP       = 3;
    localparam int PWM_P      = CLK_HZ / PWM_HZ;
    localparam int DMAX       = (PWM_P * 9) / 10;
    localparam int DW         = $clog2(PWM_P + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] v_s = '0, i_s = '0;
    logic          start_ok = 1'b0, run_ok = 1'b0;
    logic          ovc = 1'b0, ovt = 1'b0, vreg = 1'b0, ireg = 1'b0;
    logic          pwm;
    logic [DW-1:0] duty;
    logic          dir_up;
    logic [1:0]    mode;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench reference state
    int          m_mode = 0;
    int          m_duty = DMIN;
    int          m_dir = 1;
    int unsigned m_prev = 0;
    bit          m_pv = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mppt_duty_ctrl #(
        .CLK_HZ       (CLK_HZ),
        .PWM_HZ       (PWM_HZ),
        .TRACK_CYCLES (TRK),
        .SAMPLE_W     (SW),
        .DUTY_MIN     (DMIN),
        .STEP         (STEP)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_sample_i (v_s),
        .i_sample_i (i_s),
        .start_ok_i (start_ok),
        .run_ok_i   (run_ok),
        .ovc_i      (ovc),
        .ovt_i      (ovt),
        .vreg_i     (vreg),
        .ireg_i     (ireg),
        .pwm_o      (pwm),
        .duty_o     (duty),
        .dir_up_o   (dir_up),
        .mode_o     (mode)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int step_up(input int d);
        return (d + STEP > DMAX) ? DMAX : d + STEP;
    endfunction

    function automatic int step_dn(input int d);
        return (d < DMIN + STEP) ? DMIN : d - STEP;
    endfunction

    // state transitions the bench expects for steady flags
    function automatic void model_transition(input bit st, input bit rn, input bit rg);
        for (int n = 0; n < 4; n++) begin
            case (m_mode)
                0: if (st) begin m_mode = 1; m_pv = 0; end
                1: if (!rn) m_mode = 3; else if (rg) m_mode = 2;
                2: if (!rn) m_mode = 3; else if (!rg) begin m_mode = 1; m_pv = 0; end
                default: begin
                    if (!st) begin m_mode = 0; m_duty = DMIN; m_dir = 1; m_pv = 0; end
                    else if (rn) begin m_mode = 1; m_pv = 0; end
                end
            endcase
        end
    endfunction

    function automatic void model_tick(input int unsigned p, input bit stop);
        if (stop) return;
        if (m_mode == 1) begin
            if (m_pv) begin
                if (p < m_prev) m_dir = 1 - m_dir;
                m_duty = m_dir ? step_up(m_duty) : step_dn(m_duty);
            end
            m_prev = p;
            m_pv = 1;
        end else if (m_mode == 2) begin
            m_duty = step_dn(m_duty);
        end
    endfunction

    // one tracking period with steady inputs, starting at a negedge aligned to the period
    task automatic period(input string tag, input int v, input int i, input bit st,
                          input bit rn, input bit stop_c, input bit stop_t,
                          input bit rv, input bit ri);
        int hi;
        int exp_hi;
        string ptag;
        v_s = SW'(v); i_s = SW'(i);
        start_ok = st; run_ok = rn; ovc = stop_c; ovt = stop_t; vreg = rv; ireg = ri;
        model_transition(st, rn, rv | ri);
        exp_hi = ((m_mode == 1 || m_mode == 2) && !(stop_c || stop_t)) ? m_duty : 0;
        ptag = (stop_c || stop_t) ? "R7" : (m_mode == 3 ? "R10" : "R6");
        hi = 0;
        for (int k = 1; k <= TRK; k++) begin
            @(negedge clk);
            if (k >= 3 && k <= PWM_P + 2 && pwm) hi++;
        end
        model_tick(v * i, stop_c || stop_t);
        check(ptag, "pwm high count", hi, exp_hi);
        check(tag, "mode", int'(mode), m_mode);
        check(tag, "duty", int'(duty), m_duty);
        check(tag, "dir", int'(dir_up), m_dir);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        repeat (5) @(negedge clk);
        // R1: reset values
        check("R1", "reset mode", int'(mode), 0);
        check("R1", "reset duty", int'(duty), DMIN);
        check("R1", "reset dir", int'(dir_up), 1);
        check("R1", "reset pwm", int'(pwm), 0);
        rst_n = 1'b1;

        period("R1", 10, 10, 0, 0, 0, 0, 0, 0);
        period("R2", 100, 100, 1, 1, 0, 0, 0, 0);
        check("R3", "first tick keeps duty", int'(duty), DMIN);
        // R4: rising power keeps climbing; R5 clamps at the ceiling
        for (int k = 1; k <= 7; k++) period("R4", 100, 100 + 10 * k, 1, 1, 0, 0, 0, 0);
        check("R5", "ceiling clamp", int'(duty), DMAX);
        period("R4", 100, 170, 1, 1, 0, 0, 0, 0);   // equal power keeps direction
        check("R4", "equal power dir", int'(dir_up), 1);
        period("R4", 100, 150, 1, 1, 0, 0, 0, 0);   // fall reverses
        check("R4", "reversal dir", int'(dir_up), 0);
        check("R4", "reversal step", int'(duty), DMAX - STEP);
        for (int k = 1; k <= 7; k++) period("R4", 100, 150 + 10 * k, 1, 1, 0, 0, 0, 0);
        check("R5", "floor clamp", int'(duty), DMIN);
        // R7: stop across the tick with falling power
        period("R7", 100, 50, 1, 1, 1, 0, 0, 0);
        period("R7", 100, 40, 1, 1, 0, 1, 0, 0);
        check("R7", "duty frozen", int'(duty), DMIN);
        period("R4", 100, 30, 1, 1, 0, 0, 0, 0);    // fall: turn upward
        for (int k = 1; k <= 3; k++) period("R4", 100, 30 + 10 * k, 1, 1, 0, 0, 0, 0);
        // R8: regulation walks duty down
        period("R8", 100, 90, 1, 1, 0, 0, 1, 0);
        period("R8", 100, 90, 1, 1, 0, 0, 0, 1);
        check("R8", "regulation mode", int'(mode), 2);
        period("R9", 100, 10, 1, 1, 0, 0, 0, 0);
        check("R9", "release records only", int'(dir_up), 1);
        // R10 / R11: burst, priority over regulation, recovery and collapse
        period("R10", 100, 10, 1, 0, 0, 0, 1, 0);
        check("R10", "burst over regulation", int'(mode), 3);
        period("R11", 100, 5, 1, 1, 0, 0, 0, 0);
        period("R11", 100, 5, 0, 0, 0, 0, 0, 0);
        check("R11", "collapse duty", int'(duty), DMIN);

        // random phase
        r = $urandom(32'd2024);
        for (int n = 0; n < 300; n++) begin
            bit st, rn, sc, stt, rv, ri;
            st  = ($urandom % 10) != 0;
            rn  = st && (($urandom % 8) != 0);
            sc  = ($urandom % 12) == 0;
            stt = ($urandom % 15) == 0;
            rv  = ($urandom % 7) == 0;
            ri  = ($urandom % 9) == 0;
            period("R4", int'($urandom % 4096), int'($urandom % 4096), st, rn, sc, stt, rv, ri);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule